// File: doc/BRIEF.md
# Vertical Transfer Pulse Generator

This block produces the four phase clocks that move charge down the vertical registers of an area image sensor, plus four sweep pulses used to clear charge quickly. Each phase is defined by a start level and two positions, measured in pixel-clock cycles, at which the level inverts. The waveform repeats after a programmable length, and two independent pattern sets are held so that one can be chosen for each line.

A line begins with a one-cycle `line_start` pulse. At that pulse the block captures the selected pattern, the per-line repeat count and the sweep settings from the writable register file. It then runs the pattern counter for the requested number of repetitions and falls back to idle levels. Register writes go into the writable copy only, so software can prepare the next line while the current one runs. The sweep pulses run on a separate 12-bit counter that is gated by `sweep_en`.

Top module: `vtp_gen`

## Requirements
- R1: Once reset is released, `line_busy` is 0, `sp_out` is 0, and `v_out` shows the idle start levels of the default pattern: V1..V4 = 1,0,0,1, so `v_out` = 4'b1001, with bit k carrying phase k+1.
- R2: A `line_start` is accepted only when the block is idle and `rep_count` is nonzero. On acceptance, `line_busy` is 1 after the next edge and the pattern position is 0. A `line_start` with `rep_count` = 0 is ignored.
- R3: While busy at pattern position c, `v_out[k]` = pol ^ (t1 < len && c >= t1) ^ (t2 < len && c >= t2). That is, the phase inverts at the position equal to each toggle, and a toggle at or beyond the length never fires.
- R4: The position runs 0..len-1 and then wraps, with a length of 0 treated as 1. `line_busy` stays high for exactly len*rep_count cycles.
- R5: While idle, `v_out` holds the start levels of the pattern most recently captured.
- R6: A `line_start` that arrives while busy is ignored, and the running waveform and its end time are unchanged.
- R7: Write-port map, with `cfg_we` writing at the clock edge. Address 8p holds the pattern p length in bits [8:0]. Address 8p+1+k holds phase k of pattern p: toggle 1 in [8:0], toggle 2 in [17:9], start level in [18]. Address 16+k holds sweep k: toggle 1 in [11:0], toggle 2 in [23:12]. Other addresses are ignored. Writes affect outputs only from the next accepted line start.
- R8: The two patterns are stored independently, and `pat_sel` (0 or 1), sampled on acceptance, chooses which one runs.
- R9: Both patterns reset to length 99 with toggles V1 29/99, V2 15/57, V3 43/85, V4 1/71 and start levels 1,0,0,1.
- R10: While `sweep_en` is 0, the sweep counter is cleared and `sp_out` is 0. The first edge with `sweep_en` = 1 sets the count to 0. The count then increments on each edge and wraps from 4095 to 0.
- R11: `sp_out[k]` is 1 exactly when t1 <= count < t2 for sweep k. It is never 1 when t2 <= t1.
- R12: The sweep toggles reset to 40/410, 490/780, 80/360 and 450/820. The active sweep settings are captured from the register file only at an accepted line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register write address |
| cfg_wdata | input | 24 | Register write data |
| line_start | input | 1 | One-cycle line start request |
| pat_sel | input | 1 | Pattern choice, sampled at line start |
| rep_count | input | 4 | Repetitions for this line, sampled at line start |
| sweep_en | input | 1 | Runs the sweep counter while high |
| v_out | output | 4 | Vertical phases V1..V4 (bit 0 = V1) |
| sp_out | output | 4 | Sweep pulses 1..4 |
| line_busy | output | 1 | High while a line's repetitions run |

## Verification
After an accepted start edge, `v_out` shows position 0. Each later edge advances the position by one, and `line_busy` falls exactly len*rep_count edges after acceptance. `sp_out` follows the sweep count with no added register, so position j is shown j edges after the first enabled edge. The bench drives every input on the falling clock edge. It checks on the next falling edge and steps its expected position by one per cycle, so each compare lands in the cycle the result is due. Writes, ignored starts and sweep setting changes are each followed by observation of the outputs they could have disturbed before the next accepted start.

// File: rtl/vtp_pkg.sv
package vtp_pkg;
  localparam int POS_W      = 9;
  localparam int SW_W       = 12;
  localparam int N_PH       = 4;
  localparam int N_PAT      = 2;
  localparam int REP_W      = 4;
  localparam int SEL_W      = $clog2(N_PAT);
  localparam int PH_W       = 2 * POS_W + 1;
  localparam int SWC_W      = 2 * SW_W;
  localparam int DATA_W     = (PH_W > SWC_W) ? PH_W : SWC_W;
  localparam int PAT_STRIDE = 2 ** $clog2(N_PH + 1);
  localparam int SWEEP_BASE = N_PAT * PAT_STRIDE;
  localparam int ADDR_W     = $clog2(SWEEP_BASE + N_PH);

  typedef struct packed {
    logic             pol;
    logic [POS_W-1:0] t2;
    logic [POS_W-1:0] t1;
  } phase_cfg_t;

  typedef struct packed {
    logic [POS_W-1:0]            len;
    phase_cfg_t [N_PH-1:0]       ph;
  } pat_cfg_t;

  typedef struct packed {
    logic [SW_W-1:0] t2;
    logic [SW_W-1:0] t1;
  } sweep_cfg_t;

  function automatic pat_cfg_t pat_default();
    pat_cfg_t d;
    d.len   = POS_W'(99);
    d.ph[0] = '{pol: 1'b1, t2: POS_W'(99), t1: POS_W'(29)};
    d.ph[1] = '{pol: 1'b0, t2: POS_W'(57), t1: POS_W'(15)};
    d.ph[2] = '{pol: 1'b0, t2: POS_W'(85), t1: POS_W'(43)};
    d.ph[3] = '{pol: 1'b1, t2: POS_W'(71), t1: POS_W'(1)};
    return d;
  endfunction

  function automatic sweep_cfg_t sweep_default(input int k);
    sweep_cfg_t d;
    case (k)
      0:       d = '{t2: SW_W'(410), t1: SW_W'(40)};
      1:       d = '{t2: SW_W'(780), t1: SW_W'(490)};
      2:       d = '{t2: SW_W'(360), t1: SW_W'(80)};
      default: d = '{t2: SW_W'(820), t1: SW_W'(450)};
    endcase
    return d;
  endfunction

  function automatic logic [ADDR_W-1:0] len_addr(input int p);
    return ADDR_W'(p * PAT_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] phase_addr(input int p, input int k);
    return ADDR_W'(p * PAT_STRIDE + 1 + k);
  endfunction

  function automatic logic [ADDR_W-1:0] sweep_addr(input int k);
    return ADDR_W'(SWEEP_BASE + k);
  endfunction
endpackage

// File: rtl/vtp_regfile.sv
module vtp_regfile
  import vtp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output pat_cfg_t   [N_PAT-1:0]        pat_o,
  output sweep_cfg_t [N_PH-1:0]         sw_o
);
  pat_cfg_t   [N_PAT-1:0] pat_q;
  sweep_cfg_t [N_PH-1:0]  sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N_PAT; p++) pat_q[p] <= pat_default();
      for (int k = 0; k < N_PH; k++)  sw_q[k]  <= sweep_default(k);
    end else if (we) begin
      for (int p = 0; p < N_PAT; p++) begin
        if (addr == len_addr(p)) pat_q[p].len <= wdata[POS_W-1:0];
        for (int k = 0; k < N_PH; k++)
          if (addr == phase_addr(p, k)) pat_q[p].ph[k] <= wdata[PH_W-1:0];
      end
      for (int k = 0; k < N_PH; k++)
        if (addr == sweep_addr(k)) sw_q[k] <= wdata[SWC_W-1:0];
    end
  end

  assign pat_o = pat_q;
  assign sw_o  = sw_q;
endmodule

// File: rtl/vtp_line_ctrl.sv
module vtp_line_ctrl
  import vtp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    line_start,
  input  logic [SEL_W-1:0]        pat_sel,
  input  logic [REP_W-1:0]        rep_count,
  input  pat_cfg_t   [N_PAT-1:0]  shadow_pat,
  input  sweep_cfg_t [N_PH-1:0]   shadow_sw,
  output pat_cfg_t                act_pat,
  output sweep_cfg_t [N_PH-1:0]   act_sw,
  output logic [POS_W-1:0]        cnt,
  output logic                    busy
);
  pat_cfg_t              pat_q;
  sweep_cfg_t [N_PH-1:0] sw_q;
  logic [POS_W-1:0]      cnt_q;
  logic [REP_W-1:0]      reps_q;
  logic                  busy_q;
  logic                  accept;
  logic                  last;

  assign accept = line_start && !busy_q && (rep_count != '0);
  // wrap at len-1; a zero length behaves as one
  assign last   = ({1'b0, cnt_q} + 1'b1) >= {1'b0, pat_q.len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q  <= pat_default();
      for (int k = 0; k < N_PH; k++) sw_q[k] <= sweep_default(k);
      cnt_q  <= '0;
      reps_q <= '0;
      busy_q <= 1'b0;
    end else if (accept) begin
      pat_q  <= shadow_pat[pat_sel];
      sw_q   <= shadow_sw;
      cnt_q  <= '0;
      reps_q <= rep_count;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (last) begin
        cnt_q  <= '0;
        reps_q <= reps_q - 1'b1;
        if (reps_q == REP_W'(1)) busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign act_pat = pat_q;
  assign act_sw  = sw_q;
  assign cnt     = cnt_q;
  assign busy    = busy_q;
endmodule

// File: rtl/vtp_phase_out.sv
module vtp_phase_out
  import vtp_pkg::*;
(
  input  pat_cfg_t          act,
  input  logic [POS_W-1:0]  cnt,
  input  logic              busy,
  output logic [N_PH-1:0]   v
);
  for (genvar k = 0; k < N_PH; k++) begin : g_phase
    logic hit1;
    logic hit2;
    assign hit1 = (act.ph[k].t1 < act.len) && (cnt >= act.ph[k].t1);
    assign hit2 = (act.ph[k].t2 < act.len) && (cnt >= act.ph[k].t2);
    assign v[k] = busy ? (act.ph[k].pol ^ hit1 ^ hit2) : act.ph[k].pol;
  end
endmodule

// File: rtl/vtp_sweep.sv
module vtp_sweep
  import vtp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  sweep_cfg_t [N_PH-1:0]   cfg,
  output logic [N_PH-1:0]         sp,
  output logic [SW_W-1:0]         cnt_o,
  output logic                    run_o
);
  logic [SW_W-1:0] cnt_q;
  logic            run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!run_q) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar k = 0; k < N_PH; k++) begin : g_win
    assign sp[k] = run_q && (cnt_q >= cfg[k].t1) && (cnt_q < cfg[k].t2);
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/vtp_gen.sv
module vtp_gen
  import vtp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic                line_start,
  input  logic [SEL_W-1:0]    pat_sel,
  input  logic [REP_W-1:0]    rep_count,
  input  logic                sweep_en,
  output logic [N_PH-1:0]     v_out,
  output logic [N_PH-1:0]     sp_out,
  output logic                line_busy
);
  pat_cfg_t   [N_PAT-1:0] shadow_pat;
  sweep_cfg_t [N_PH-1:0]  shadow_sw;
  pat_cfg_t               act_pat;
  sweep_cfg_t [N_PH-1:0]  act_sw;
  logic [POS_W-1:0]       pat_cnt;
  logic [POS_W-1:0]       pat_len;
  logic [SW_W-1:0]        sw_cnt;
  logic                   sw_run;

  vtp_regfile u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .pat_o (shadow_pat),
    .sw_o  (shadow_sw)
  );

  vtp_line_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .pat_sel    (pat_sel),
    .rep_count  (rep_count),
    .shadow_pat (shadow_pat),
    .shadow_sw  (shadow_sw),
    .act_pat    (act_pat),
    .act_sw     (act_sw),
    .cnt        (pat_cnt),
    .busy       (line_busy)
  );

  vtp_phase_out u_phase (
    .act  (act_pat),
    .cnt  (pat_cnt),
    .busy (line_busy),
    .v    (v_out)
  );

  vtp_sweep u_sweep (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sweep_en),
    .cfg   (act_sw),
    .sp    (sp_out),
    .cnt_o (sw_cnt),
    .run_o (sw_run)
  );

  assign pat_len = act_pat.len;
endmodule

// File: rtl/vtp_gen_chk.sv
module vtp_gen_chk
  import vtp_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               line_start,
  input logic [REP_W-1:0]   rep_count,
  input logic               sweep_en,
  input logic [N_PH-1:0]    v_out,
  input logic [N_PH-1:0]    sp_out,
  input logic               line_busy,
  input logic [POS_W-1:0]   pat_cnt,
  input logic [POS_W-1:0]   pat_len,
  input logic [SW_W-1:0]    sw_cnt,
  input logic               sw_run
);
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !line_busy && rep_count != '0) |=> line_busy); // R2

  AST_ZERO_REP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !line_busy && rep_count == '0) |=> !line_busy); // R2

  AST_FIRST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_busy) |-> (pat_cnt == '0)); // R2

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    line_busy |-> (pat_cnt == '0 || pat_cnt < pat_len)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_busy && !(line_start && rep_count != '0)) |=> $stable(v_out)); // R5

  AST_SWEEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_en |=> (sp_out == '0 && sw_cnt == '0)); // R10

  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_en && sw_run) |=> (sw_cnt == $past(sw_cnt) + 1'b1)); // R10

  AST_SWEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_out != '0) |-> sw_run); // R11
endmodule

bind vtp_gen vtp_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .rep_count  (rep_count),
  .sweep_en   (sweep_en),
  .v_out      (v_out),
  .sp_out     (sp_out),
  .line_busy  (line_busy),
  .pat_cnt    (pat_cnt),
  .pat_len    (pat_len),
  .sw_cnt     (sw_cnt),
  .sw_run     (sw_run)
);

// File: tb/tb_vtp_gen.sv
module tb_vtp_gen;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [23:0] cfg_wdata;
  logic        line_start;
  logic        pat_sel;
  logic [3:0]  rep_count;
  logic        sweep_en;
  logic [3:0]  v_out;
  logic [3:0]  sp_out;
  logic        line_busy;

  int n_chk  = 0;
  int n_fail = 0;

  // register-file model (writable copy) and captured copy
  int m_len[2];
  int m_pol[2][4];
  int m_t1[2][4];
  int m_t2[2][4];
  int m_s1[4];
  int m_s2[4];
  int a_len;
  int a_pol[4];
  int a_t1[4];
  int a_t2[4];
  int a_s1[4];
  int a_s2[4];

  always #(CLK_P / 2) clk = ~clk;

  vtp_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .line_start(line_start), .pat_sel(pat_sel),
    .rep_count(rep_count), .sweep_en(sweep_en), .v_out(v_out),
    .sp_out(sp_out), .line_busy(line_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    int dp[4] = '{1, 0, 0, 1};
    int d1[4] = '{29, 15, 43, 1};
    int d2[4] = '{99, 57, 85, 71};
    int s1[4] = '{40, 490, 80, 450};
    int s2[4] = '{410, 780, 360, 820};
    for (int p = 0; p < 2; p++) begin
      m_len[p] = 99;
      for (int k = 0; k < 4; k++) begin
        m_pol[p][k] = dp[k]; m_t1[p][k] = d1[k]; m_t2[p][k] = d2[k];
      end
    end
    for (int k = 0; k < 4; k++) begin
      m_s1[k] = s1[k]; m_s2[k] = s2[k];
      a_s1[k] = s1[k]; a_s2[k] = s2[k];
      a_pol[k] = dp[k]; a_t1[k] = d1[k]; a_t2[k] = d2[k];
    end
    a_len = 99;
  endfunction

  // R7 address and field layout
  function automatic void model_write(input int a, input int d);
    if (a < 16) begin
      int p = a / 8;
      int o = a % 8;
      if (o == 0) m_len[p] = d & 511;
      else if (o <= 4) begin
        m_t1[p][o-1]  = d & 511;
        m_t2[p][o-1]  = (d >> 9) & 511;
        m_pol[p][o-1] = (d >> 18) & 1;
      end
    end else if (a < 20) begin
      m_s1[a-16] = d & 4095;
      m_s2[a-16] = (d >> 12) & 4095;
    end
  endfunction

  function automatic void capture(input int sel);
    a_len = m_len[sel];
    for (int k = 0; k < 4; k++) begin
      a_pol[k] = m_pol[sel][k]; a_t1[k] = m_t1[sel][k]; a_t2[k] = m_t2[sel][k];
      a_s1[k] = m_s1[k]; a_s2[k] = m_s2[k];
    end
  endfunction

  function automatic int exp_v(input int c);
    int r = 0;
    for (int k = 0; k < 4; k++) begin
      int b = a_pol[k];
      if (a_t1[k] < a_len && c >= a_t1[k]) b ^= 1;
      if (a_t2[k] < a_len && c >= a_t2[k]) b ^= 1;
      r |= b << k;
    end
    return r;
  endfunction

  function automatic int idle_v();
    int r = 0;
    for (int k = 0; k < 4; k++) r |= a_pol[k] << k;
    return r;
  endfunction

  function automatic int exp_sp(input int c);
    int r = 0;
    for (int k = 0; k < 4; k++)
      if (c >= a_s1[k] && c < a_s2[k]) r |= 1 << k;
    return r;
  endfunction

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 24'(d);
    model_write(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // runs one line and checks every cycle; optional injected start or write
  task automatic run_line(input int sel, input int rep, input int inj_ls,
                          input int inj_wr, input int wa, input int wd);
    int L;
    int total;
    line_start = 1'b1; pat_sel = 1'(sel); rep_count = 4'(rep);
    @(negedge clk);
    line_start = 1'b0; rep_count = '0;
    capture(sel);
    L = (a_len == 0) ? 1 : a_len;
    total = L * rep;
    for (int j = 0; j < total; j++) begin
      chk("R3 phase levels", int'(v_out), exp_v(j % L));
      chk((j == 0) ? "R2 start accepted" : "R4 busy during line", int'(line_busy), 1);
      line_start = (j == inj_ls);
      if (j == inj_ls) begin pat_sel = 1'(1 - sel); rep_count = 4'd5; end
      cfg_we = (j == inj_wr);
      if (j == inj_wr) begin
        cfg_addr = 5'(wa); cfg_wdata = 24'(wd); model_write(wa, wd);
      end
      @(negedge clk);
    end
    line_start = 1'b0; cfg_we = 1'b0; rep_count = '0;
    chk("R4 line ends after len*reps", int'(line_busy), 0);
    chk("R5 idle levels", int'(v_out), idle_v());
  endtask

  task automatic run_sweep(input int n);
    sweep_en = 1'b1;
    @(negedge clk);
    for (int j = 0; j < n; j++) begin
      chk("R11 sweep window", int'(sp_out), exp_sp(j % 4096));
      @(negedge clk);
    end
    sweep_en = 1'b0;
    @(negedge clk);
    chk("R10 sweep off", int'(sp_out), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    line_start = 1'b0; pat_sel = 1'b0; rep_count = '0; sweep_en = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", int'(line_busy), 0);
    chk("R1 reset levels", int'(v_out), 4'b1001);
    chk("R1 reset sweep", int'(sp_out), 0);

    // R9 defaults of both patterns, R8 selection, R4 repeats
    run_line(0, 1, -1, -1, 0, 0);
    run_line(1, 2, -1, -1, 0, 0);

    // R7 rewrite pattern 0, toggles beyond length and at zero
    wr(0, 10);
    wr(1, (1 << 18) | (3 << 9) | 0);
    wr(2, (0 << 18) | (12 << 9) | 4);
    wr(3, (1 << 18) | (9 << 9) | 10);
    wr(4, (0 << 18) | (5 << 9) | 5);
    wr(6, 24'hFFFFFF);          // R7 unused address
    run_line(0, 3, -1, -1, 0, 0);
    run_line(1, 1, -1, -1, 0, 0); // R8 pattern 1 untouched

    // R2 zero repeat count is ignored
    line_start = 1'b1; pat_sel = 1'b0; rep_count = '0;
    @(negedge clk);
    line_start = 1'b0;
    chk("R2 zero reps ignored busy", int'(line_busy), 0);
    chk("R2 zero reps ignored levels", int'(v_out), idle_v());

    // R6 start while busy ignored
    run_line(0, 2, 3, -1, 0, 0);
    // R7 write while busy does not disturb the running line
    run_line(0, 2, -1, 2, 1, (0 << 18) | (7 << 9) | 2);
    run_line(0, 1, -1, -1, 0, 0);

    // R4 zero length behaves as one
    wr(8, 0);
    run_line(1, 3, -1, -1, 0, 0);

    // constrained random lines
    for (int it = 0; it < 10; it++) begin
      int sel = $urandom_range(1, 0);
      wr(sel * 8, $urandom_range(30, 1));
      for (int k = 0; k < 4; k++)
        wr(sel * 8 + 1 + k, ($urandom_range(1, 0) << 18) |
                            ($urandom_range(35, 0) << 9) | $urandom_range(35, 0));
      run_line(sel, $urandom_range(3, 1), -1, -1, 0, 0);
    end

    // R12 sweep defaults; R10 wrap past 4095
    run_sweep(4100);

    // R12 sweep writes wait for a line start; R11 t2 <= t1 never high
    wr(16, (3 << 12) | 5);
    wr(17, (7 << 12) | 0);
    run_sweep(20);
    wr(0, 2);
    run_line(0, 1, -1, -1, 0, 0);
    run_sweep(20);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule